// File: doc/BRIEF.md
# Word-to-Byte Bus Conversion Sequencer

This block joins a host bus with a 16-bit data path to a target bus that carries only one byte at a time. For every host request it first decodes the two byte-lane qualifiers: the least significant address bit and an active-high high-byte enable. A request for a whole word is broken into two byte sub-cycles, the even byte first and the odd byte second. A request for a single byte passes through as one sub-cycle. For reads, the byte from the first half is held in a register while the second half runs. The odd byte is steered between the high lane of the host and the single lane of the target in both directions. The host sees one ready pulse after the last target handshake.

The controller is a five-state machine. The states and transitions are:
- IDLE to FIRST on a valid request.
- IDLE to DONE on an invalid lane combination.
- FIRST to GAP on a target ready during a word cycle.
- FIRST to DONE on a target ready during a byte cycle.
- GAP to SECOND unconditionally. GAP takes the strobe down for one clock so that the target latches a fresh address.
- SECOND to DONE on a target ready.
- DONE to IDLE unconditionally, giving the host its ready pulse.

A synchronous reset returns the machine to IDLE from any state.

The host keeps its request and qualifiers steady until it sees `hst_ready`. It then withdraws the request on the next clock.

Top module: `bwb_bridge`

## Requirements
- R1: Lane decode, with A0 = `hst_addr[0]` and `hst_hi_en` active high: A0=0 with hi_en=1 is a word, A0=0 with hi_en=0 is a low-lane byte, and A0=1 with hi_en=1 is a high-lane byte.
- R2: A0=1 with hi_en=0 is invalid. The block raises `hst_err` together with `hst_ready` one clock after acceptance, and it issues no target strobe.
- R3: A word read reads the even address first and the odd address second. It returns `hst_rdata` = {odd byte, even byte}.
- R4: A word write sends `hst_wdata[7:0]` to the even address and then `hst_wdata[15:8]` to the odd address, both on `tgt_wdata`.
- R5: A high-lane byte makes one sub-cycle at the odd address. A write sends `hst_wdata[15:8]`. A read returns the byte on `hst_rdata[15:8]` with `hst_rdata[7:0]` = 0.
- R6: A low-lane byte makes one sub-cycle at the even address. A write sends `hst_wdata[7:0]`. A read returns the byte on `hst_rdata[7:0]` with `hst_rdata[15:8]` = 0.
- R7: Between the two halves of a word, `tgt_stb` is low for exactly one clock, so the target sees two separate strobes.
- R8: While `tgt_stb` is high and `tgt_ready` is low, `tgt_stb`, `tgt_addr`, `tgt_we` and `tgt_wdata` hold their values.
- R9: `hst_ready` is a one-clock pulse and never coincides with `tgt_stb`. With w wait clocks per sub-cycle, it appears 4+2w clocks after acceptance for a word and 2+w clocks for a byte.
- R10: A synchronous reset abandons any cycle in progress, drops `tgt_stb`, `hst_ready` and `hst_err`, and the next request runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hst_req | input | 1 | Host request, held until `hst_ready` |
| hst_addr | input | ADDR_W | Host byte address; bit 0 is the lane qualifier A0 |
| hst_hi_en | input | 1 | High-byte lane enable, active high |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid with `hst_ready` |
| hst_ready | output | 1 | One-clock completion pulse |
| hst_err | output | 1 | Invalid lane combination, valid with `hst_ready` |
| tgt_addr | output | ADDR_W | Target byte address with forced bit 0 |
| tgt_stb | output | 1 | Target address strobe, high for a sub-cycle |
| tgt_we | output | 1 | Target write direction |
| tgt_wdata | output | 8 | Target write byte |
| tgt_rdata | input | 8 | Target read byte |
| tgt_ready | input | 1 | Target completion, may come in the strobe's first clock |

## Verification
If the machine skips GAP, the target sees one long strobe where it should see two. A swapped lane select shows up as the wrong byte on `tgt_wdata` or on the wrong half of `hst_rdata` in the very sub-cycle where the swap occurs. A stuck or early DONE shows up as a `hst_ready` pulse at the wrong clock count or as one that overlaps a strobe. A lost hold of the first byte corrupts `hst_rdata[7:0]` only at the end of a word read, so every word read compares both lanes against the target's contents.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

    typedef enum logic [1:0] {
        K_WORD,
        K_LO,
        K_HI,
        K_BAD
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FIRST,
        S_GAP,
        S_SECOND,
        S_DONE
    } state_e;

endpackage

// File: rtl/bwb_lane_decode.sv
module bwb_lane_decode
    import bwb_pkg::*;
(
    input  logic  a0,
    input  logic  hi_en,
    output kind_e kind
);

    always_comb begin
        unique case ({a0, hi_en})
            2'b01:   kind = K_WORD;
            2'b00:   kind = K_LO;
            2'b11:   kind = K_HI;
            default: kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/bwb_seq.sv
module bwb_seq
    import bwb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  kind_e             kind,
    input  logic              t_ready,
    output logic              accept,
    output logic              t_stb,
    output logic [ADDR_W-1:0] t_addr,
    output logic              t_we,
    output logic              lane_hi,
    output logic              cap_en,
    output logic              h_ready,
    output logic              h_err
);

    localparam int BASE_W = ADDR_W - 1;

    state_e            state, state_nx;
    kind_e             kind_q;
    logic [BASE_W-1:0] base_q;
    logic              we_q;
    logic              err_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req) state_nx = (kind == K_BAD) ? S_DONE : S_FIRST;
            S_FIRST:  if (t_ready) state_nx = (kind_q == K_WORD) ? S_GAP : S_DONE;
            S_GAP:    state_nx = S_SECOND;
            S_SECOND: if (t_ready) state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            kind_q <= K_LO;
            base_q <= '0;
            we_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && req) begin
                kind_q <= kind;
                base_q <= addr[ADDR_W-1:1];
                we_q   <= we;
                err_q  <= (kind == K_BAD);
            end else if (state == S_DONE) begin
                err_q <= 1'b0;
            end
        end
    end

    always_comb begin
        accept  = (state == S_IDLE) && req;
        t_stb   = (state == S_FIRST) || (state == S_SECOND);
        lane_hi = (state == S_SECOND) || (kind_q == K_HI);
        t_addr  = {base_q, lane_hi};
        t_we    = we_q;
        cap_en  = t_stb && t_ready && !we_q;
        h_ready = (state == S_DONE);
        h_err   = (state == S_DONE) && err_q;
    end

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        h_ready |=> !h_ready);

    // R9
    ready_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
        h_ready |-> !t_stb);

    // R2
    err_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        h_err |-> h_ready);

    // R7
    gap_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
        (t_stb && t_ready && kind_q == K_WORD && !lane_hi) |=> (!t_stb ##1 t_stb));

endmodule

// File: rtl/bwb_data.sv
module bwb_data (
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic [15:0] h_wdata,
    input  logic        lane_hi,
    input  logic        cap_en,
    input  logic [7:0]  t_rdata,
    output logic [7:0]  t_wdata,
    output logic [15:0] h_rdata
);

    logic [15:0] wbuf_q;
    logic [7:0]  lo_q;
    logic [7:0]  hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (accept) begin
            wbuf_q <= h_wdata;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (cap_en) begin
            if (lane_hi) hi_q <= t_rdata;
            else         lo_q <= t_rdata;
        end
    end

    always_comb begin
        t_wdata = lane_hi ? wbuf_q[15:8] : wbuf_q[7:0];
        h_rdata = {hi_q, lo_q};
    end

    // R3: the held low byte survives the second half
    lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_en && lane_hi) |=> $stable(lo_q));

endmodule

// File: rtl/bwb_bridge.sv
module bwb_bridge
    import bwb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_req,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_hi_en,
    input  logic              hst_we,
    input  logic [15:0]       hst_wdata,
    output logic [15:0]       hst_rdata,
    output logic              hst_ready,
    output logic              hst_err,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              tgt_stb,
    output logic              tgt_we,
    output logic [7:0]        tgt_wdata,
    input  logic [7:0]        tgt_rdata,
    input  logic              tgt_ready
);

    kind_e kind;
    logic  accept;
    logic  lane_hi;
    logic  cap_en;

    bwb_lane_decode u_dec (
        .a0    (hst_addr[0]),
        .hi_en (hst_hi_en),
        .kind  (kind)
    );

    bwb_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (hst_req),
        .addr    (hst_addr),
        .we      (hst_we),
        .kind    (kind),
        .t_ready (tgt_ready),
        .accept  (accept),
        .t_stb   (tgt_stb),
        .t_addr  (tgt_addr),
        .t_we    (tgt_we),
        .lane_hi (lane_hi),
        .cap_en  (cap_en),
        .h_ready (hst_ready),
        .h_err   (hst_err)
    );

    bwb_data u_data (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .h_wdata (hst_wdata),
        .lane_hi (lane_hi),
        .cap_en  (cap_en),
        .t_rdata (tgt_rdata),
        .t_wdata (tgt_wdata),
        .h_rdata (hst_rdata)
    );

    // R8
    tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_stb && !tgt_ready) |=> (tgt_stb && $stable(tgt_addr)
                                     && $stable(tgt_we) && $stable(tgt_wdata)));

endmodule

// File: tb/test_bwb_bridge.sv
`timescale 1ns/1ps
module test_bwb_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_req = 1'b0;
    logic [15:0] hst_addr = '0;
    logic        hst_hi_en = 1'b0;
    logic        hst_we = 1'b0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic        hst_ready, hst_err;
    logic [15:0] tgt_addr;
    logic        tgt_stb, tgt_we, tgt_ready;
    logic [7:0]  tgt_wdata, tgt_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    bwb_bridge #(.ADDR_W(16)) i_bwb_bridge (
        .clk(clk), .rst(rst), .hst_req(hst_req), .hst_addr(hst_addr),
        .hst_hi_en(hst_hi_en), .hst_we(hst_we), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_ready(hst_ready), .hst_err(hst_err),
        .tgt_addr(tgt_addr), .tgt_stb(tgt_stb), .tgt_we(tgt_we),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata), .tgt_ready(tgt_ready)
    );

    // byte-wide target model
    logic [7:0]  mem [0:255];
    int          wcnt = 0;
    int          tgt_wait = 0;
    int          n_xfer = 0;
    int          n_rise = 0;
    logic        stb_d = 1'b0;
    logic [15:0] log_addr [0:15];
    logic [7:0]  log_wd   [0:15];

    assign tgt_ready = tgt_stb && (wcnt >= tgt_wait);
    assign tgt_rdata = mem[tgt_addr[7:0]];

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);

    always @(posedge clk) begin
        stb_d <= tgt_stb;
        if (tgt_stb && !stb_d) n_rise <= n_rise + 1;
        if (tgt_stb && !tgt_ready) wcnt <= wcnt + 1;
        else                       wcnt <= 0;
        if (tgt_stb && tgt_ready) begin
            log_addr[n_xfer & 15] <= tgt_addr;
            log_wd[n_xfer & 15]   <= tgt_wdata;
            n_xfer <= n_xfer + 1;
            if (tgt_we) mem[tgt_addr[7:0]] <= tgt_wdata;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // runs one host cycle; returns read data, error flag and clocks to ready
    task automatic host_cycle(input logic [15:0] a, input logic hi, input logic we,
                              input logic [15:0] wd, output logic [15:0] rd,
                              output logic er, output int cyc);
        @(negedge clk);
        hst_addr = a; hst_hi_en = hi; hst_we = we; hst_wdata = wd; hst_req = 1'b1;
        cyc = 0;
        rd = '0; er = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            cyc++;
            if (hst_ready) begin
                rd = hst_rdata; er = hst_err;
                break;
            end
        end
        hst_req = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 reset stb", 32'(tgt_stb), 0);
        check("R10 reset ready", 32'(hst_ready), 0);
        check("R10 reset err", 32'(hst_err), 0);
    endtask

    task automatic t_word_read(input logic [7:0] a, input int w);
        logic [15:0] rd; logic er; int cyc; int x0, r0;
        logic [15:0] exp;
        tgt_wait = w;
        exp = {mem[a | 8'h1], mem[a]};
        x0 = n_xfer; r0 = n_rise;
        host_cycle({8'h0, a}, 1'b1, 1'b0, 16'h0, rd, er, cyc);
        @(negedge clk);
        check("R3 word read data", 32'(rd), 32'(exp));
        check("R1 word sub-cycles", 32'(n_xfer - x0), 2);
        check("R3 first addr even", 32'(log_addr[x0 & 15]), 32'(a));
        check("R3 second addr odd", 32'(log_addr[(x0 + 1) & 15]), 32'(a | 8'h1));
        check("R7 two strobes", 32'(n_rise - r0), 2);
        check("R9 word latency", 32'(cyc), 32'(4 + 2 * w));
        check("R2 no err on word", 32'(er), 0);
    endtask

    task automatic t_word_write(input logic [7:0] a, input logic [15:0] wd, input int w);
        logic [15:0] rd; logic er; int cyc; int x0;
        tgt_wait = w;
        x0 = n_xfer;
        host_cycle({8'h0, a}, 1'b1, 1'b1, wd, rd, er, cyc);
        @(negedge clk);
        check("R4 even byte", 32'(mem[a]), 32'(wd[7:0]));
        check("R4 odd byte", 32'(mem[a | 8'h1]), 32'(wd[15:8]));
        check("R4 first wdata lane", 32'(log_wd[x0 & 15]), 32'(wd[7:0]));
        check("R4 second wdata swapped", 32'(log_wd[(x0 + 1) & 15]), 32'(wd[15:8]));
        check("R9 word write latency", 32'(cyc), 32'(4 + 2 * w));
    endtask

    task automatic t_byte_lo(input logic [7:0] a, input int w);
        logic [15:0] rd; logic er; int cyc; int x0;
        tgt_wait = w;
        x0 = n_xfer;
        host_cycle({8'h0, a}, 1'b0, 1'b0, 16'h0, rd, er, cyc);
        check("R6 low read", 32'(rd), 32'({8'h00, mem[a]}));
        check("R9 byte latency", 32'(cyc), 32'(2 + w));
        host_cycle({8'h0, a}, 1'b0, 1'b1, 16'hA55C, rd, er, cyc);
        @(negedge clk);
        check("R6 low write", 32'(mem[a]), 32'h5C);
        check("R6 one sub-cycle each", 32'(n_xfer - x0), 2);
        check("R6 low addr", 32'(log_addr[(x0 + 1) & 15]), 32'(a));
    endtask

    task automatic t_byte_hi(input logic [7:0] a, input int w);
        logic [15:0] rd; logic er; int cyc; int x0;
        tgt_wait = w;
        x0 = n_xfer;
        host_cycle({8'h0, a}, 1'b1, 1'b0, 16'h0, rd, er, cyc);
        check("R5 high read", 32'(rd), 32'({mem[a], 8'h00}));
        check("R9 high byte latency", 32'(cyc), 32'(2 + w));
        host_cycle({8'h0, a}, 1'b1, 1'b1, 16'h3CE1, rd, er, cyc);
        @(negedge clk);
        check("R5 high write swapped", 32'(mem[a]), 32'h3C);
        check("R5 neighbour untouched", 32'(n_xfer - x0), 2);
        check("R5 high addr", 32'(log_addr[x0 & 15]), 32'(a));
    endtask

    task automatic t_invalid(input logic [7:0] a);
        logic [15:0] rd; logic er; int cyc; int x0, r0;
        tgt_wait = 0;
        x0 = n_xfer; r0 = n_rise;
        host_cycle({8'h0, a}, 1'b0, 1'b1, 16'hFFFF, rd, er, cyc);
        @(negedge clk);
        check("R2 err flag", 32'(er), 1);
        check("R2 latency", 32'(cyc), 1);
        check("R2 no strobe", 32'(n_rise - r0), 0);
        check("R2 no transfer", 32'(n_xfer - x0), 0);
    endtask

    task automatic t_reset_mid;
        tgt_wait = 5;
        @(negedge clk);
        hst_addr = 16'h0040; hst_hi_en = 1'b1; hst_we = 1'b0; hst_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 strobe before reset", 32'(tgt_stb), 1);
        rst = 1'b1; hst_req = 1'b0;
        @(negedge clk);
        check("R10 stb dropped", 32'(tgt_stb), 0);
        check("R10 ready low", 32'(hst_ready), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 stays idle", 32'(tgt_stb), 0);
        t_word_read(8'h40, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word_read(8'h10, 0);
        t_word_read(8'hFE, 2);
        t_word_write(8'h20, 16'hBEEF, 0);
        t_word_write(8'h30, 16'h1234, 3);
        t_word_read(8'h20, 1);
        t_byte_lo(8'h52, 0);
        t_byte_lo(8'h54, 2);
        t_byte_hi(8'h61, 0);
        t_byte_hi(8'h63, 1);
        t_invalid(8'h71);
        t_word_read(8'h70, 0);
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog actual=hang expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule